// File: doc/BRIEF.md
# Converter Clock and Calibration Sequencer

This block is the digital timing and start-up controller of a two-channel audio converter. It runs entirely from one master clock. A rate-select input states whether the master clock is 256 or 384 times the output word rate. The block derives a bit clock at 128 times the word rate from it. It also derives a left/right word strobe that changes level every 64 bit clocks. The bit clock can feed the analog section's clock input.

A digital power-down input freezes and clears all timing while it is high. When the input is released, and likewise when synchronous reset ends, the block runs an offset-calibration sequence of a fixed number of full left/right word periods. A calibrate flag is high for the whole sequence. The analog side can use that flag directly to switch each channel's modulator input over to its zero-level reference. Raising power-down during the sequence aborts it, and the next release starts a complete new sequence.

Top module: `conv_clk_cal_seq`

## Requirements
- R1: While reset is high, and from the first clock edge at which power-down is sampled high, `bclk_o`, `bclk_tick_o`, `lrck_o` and `cal_o` are all 0.
- R2: With `rate_sel_i` = 0 (256x mode), `bclk_o` has a period of 2 master clocks, high for 1 and low for 1.
- R3: With `rate_sel_i` = 1 (384x mode), `bclk_o` has a period of 3 master clocks, high for 2 and low for 1.
- R4: `bclk_tick_o` is a single-cycle pulse, once per bit-clock period, raised only in the last cycle in which `bclk_o` is high; after it, `bclk_o` is low.
- R5: After a release, `lrck_o` starts at 0 (left half) and changes level only after every `HALF_BCLKS` tick pulses, so each half lasts `HALF_BCLKS` × (2 or 3) master clocks.
- R6: The first clock edge that samples power-down low after it was high sets `cal_o` to 1. `cal_o` then stays high for exactly 2 × `HALF_BCLKS` × `CAL_WORDS` × (2 or 3) master clocks, which is `CAL_WORDS` full left/right periods.
- R7: Once the sequence completes, `cal_o` stays low while `bclk_o` and `lrck_o` keep running, as long as power-down stays low.
- R8: Raising power-down during calibration clears `cal_o` at the next edge. The next release runs a sequence of the full length from zero.
- R9: The end of synchronous reset acts as a power-down release: with power-down low, `cal_o` rises at the first edge after reset and runs the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256x or 384x word rate) |
| rst | input | 1 | Synchronous reset, active high; stands in for power application |
| rate_sel_i | input | 1 | 0: master clock is 256x word rate; 1: 384x |
| pdn_i | input | 1 | Digital power-down, active high |
| bclk_o | output | 1 | Derived bit clock, 128x word rate |
| bclk_tick_o | output | 1 | One-cycle enable in the last high cycle of each bit-clock period |
| lrck_o | output | 1 | Left/right word strobe, 0 = left half |
| cal_o | output | 1 | Calibration in progress; may drive the zero-reference input switch |

## Verification
The bench builds the block with `HALF_BCLKS` = 4 and `CAL_WORDS` = 5. With these values a whole calibration sequence lasts 80 master clocks in 256x mode and 120 in 384x mode, instead of about a million. Every sequence can therefore be timed cycle by cycle from release to completion in both rates, together with the strobe half-lengths and the tick count. The short sequence also leaves room to abort one part-way and to watch the free-running clocks after completion.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic {
        RATE_256X = 1'b0,
        RATE_384X = 1'b1
    } rate_mode_e;

    localparam int unsigned PH_W = 2;

    // final phase index of one bit-clock period: divide by 2 or by 3
    function automatic logic [PH_W-1:0] last_phase(input rate_mode_e m);
        return (m == RATE_384X) ? PH_W'(2) : PH_W'(1);
    endfunction

endpackage

// File: rtl/ccs_clkdiv.sv
module ccs_clkdiv
    import ccs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic rate_sel_i,
    output logic bclk_o,
    output logic tick_o
);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            bclk;
    } div_state_t;

    div_state_t      div_d, div_q;
    logic [PH_W-1:0] last_ph;

    always_comb begin
        last_ph = last_phase(rate_mode_e'(rate_sel_i));
        div_d   = div_q;
        // a phase beyond the last one (rate changed mid-period) also wraps
        tick_o  = !hold_i && (div_q.ph >= last_ph);
        if (hold_i || tick_o) begin
            div_d.ph = '0;
        end else begin
            div_d.ph = div_q.ph + PH_W'(1);
        end
        div_d.bclk = (div_d.ph != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign bclk_o = div_q.bclk;

endmodule

// File: rtl/ccs_framer.sv
module ccs_framer #(
    parameter int unsigned HALF_BCLKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic tick_i,
    output logic lrck_o,
    output logic word_end_o
);

    localparam int unsigned BC_W = (HALF_BCLKS > 1) ? $clog2(HALF_BCLKS) : 1;
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(HALF_BCLKS - 1);

    typedef struct packed {
        logic [BC_W-1:0] bc;
        logic            lr;
    } frm_state_t;

    frm_state_t frm_d, frm_q;
    logic       half_end;

    always_comb begin
        frm_d      = frm_q;
        half_end   = tick_i && (frm_q.bc == BC_LAST);
        word_end_o = half_end && frm_q.lr;
        if (hold_i) begin
            frm_d = '0;
        end else if (tick_i) begin
            if (half_end) begin
                frm_d.bc = '0;
                frm_d.lr = !frm_q.lr;
            end else begin
                frm_d.bc = frm_q.bc + BC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign lrck_o = frm_q.lr;

endmodule

// File: rtl/ccs_calseq.sv
module ccs_calseq #(
    parameter int unsigned CAL_WORDS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_i,
    input  logic word_end_i,
    output logic cal_o,
    output logic hold_o
);

    localparam int unsigned CW_W = (CAL_WORDS > 1) ? $clog2(CAL_WORDS) : 1;
    localparam logic [CW_W-1:0] CW_LAST = CW_W'(CAL_WORDS - 1);

    typedef struct packed {
        logic            pd;
        logic            cal;
        logic [CW_W-1:0] cnt;
    } cal_state_t;

    cal_state_t cal_d, cal_q;

    always_comb begin
        cal_d    = cal_q;
        cal_d.pd = pdn_i;
        if (pdn_i) begin
            cal_d.cal = 1'b0;
            cal_d.cnt = '0;
        end else if (cal_q.pd) begin
            // release edge: start a fresh sequence
            cal_d.cal = 1'b1;
            cal_d.cnt = '0;
        end else if (cal_q.cal && word_end_i) begin
            if (cal_q.cnt == CW_LAST) begin
                cal_d.cal = 1'b0;
                cal_d.cnt = '0;
            end else begin
                cal_d.cnt = cal_q.cnt + CW_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q     <= '0;
            cal_q.pd  <= 1'b1;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign cal_o  = cal_q.cal;
    assign hold_o = cal_q.pd || pdn_i;

endmodule

// File: rtl/conv_clk_cal_seq.sv
module conv_clk_cal_seq #(
    parameter int unsigned HALF_BCLKS = 64,
    parameter int unsigned CAL_WORDS  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel_i,
    input  logic pdn_i,
    output logic bclk_o,
    output logic bclk_tick_o,
    output logic lrck_o,
    output logic cal_o
);

    logic cal_hold;
    logic word_end;

    ccs_calseq #(
        .CAL_WORDS (CAL_WORDS)
    ) u_calseq (
        .clk        (clk),
        .rst        (rst),
        .pdn_i      (pdn_i),
        .word_end_i (word_end),
        .cal_o      (cal_o),
        .hold_o     (cal_hold)
    );

    ccs_clkdiv u_clkdiv (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (cal_hold),
        .rate_sel_i (rate_sel_i),
        .bclk_o     (bclk_o),
        .tick_o     (bclk_tick_o)
    );

    ccs_framer #(
        .HALF_BCLKS (HALF_BCLKS)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (cal_hold),
        .tick_i     (bclk_tick_o),
        .lrck_o     (lrck_o),
        .word_end_o (word_end)
    );

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker (
    input logic clk,
    input logic rst,
    input logic pdn,
    input logic bclk,
    input logic tick,
    input logic lrck,
    input logic cal,
    input logic hold,
    input logic word_end
);

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        pdn |=> (!bclk && !lrck && !cal && !tick)); // R1

    AST_TICK_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        tick |-> bclk); // R4

    AST_TICK_THEN_LOW: assert property (@(posedge clk) disable iff (rst)
        tick |=> !bclk); // R4

    AST_LRCK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lrck) && !$past(rst) && !$past(pdn)) |-> $past(tick)); // R5

    AST_CAL_START: assert property (@(posedge clk) disable iff (rst)
        $fell(pdn) |=> cal); // R6

    AST_CAL_END_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(cal) && !$past(rst)) |-> ($past(pdn) || $past(word_end))); // R7

    AST_CAL_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(cal) && !$past(rst)) |-> ($past(hold) && !$past(pdn))); // R9

endmodule

bind conv_clk_cal_seq ccs_checker u_ccs_checker (
    .clk      (clk),
    .rst      (rst),
    .pdn      (pdn_i),
    .bclk     (bclk_o),
    .tick     (bclk_tick_o),
    .lrck     (lrck_o),
    .cal      (cal_o),
    .hold     (cal_hold),
    .word_end (word_end)
);

// File: tb/tb_conv_clk_cal_seq.sv
module tb_conv_clk_cal_seq;

    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int CALW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_sel = 1'b0;
    logic pdn = 1'b0;
    logic bclk, tick, lrck, cal;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_clk_cal_seq #(
        .HALF_BCLKS (HALF),
        .CAL_WORDS  (CALW)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .rate_sel_i  (rate_sel),
        .pdn_i       (pdn),
        .bclk_o      (bclk),
        .bclk_tick_o (tick),
        .lrck_o      (lrck),
        .cal_o       (cal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // samples from the first cycle after a release until cal drops
    task automatic measure(output int cal_len, output int lr_low, output int lr_high,
                           output int hi_run, output int lo_run,
                           output int ticks, output int bad);
        int ph = 0;
        int hr = 0;
        int lrn = 0;
        cal_len = 0; lr_low = 0; lr_high = 0; hi_run = 0; lo_run = 0;
        ticks = 0; bad = 0;
        @(negedge clk);
        while (cal && cal_len < 5000) begin
            cal_len++;
            if (tick) begin
                ticks++;
                if (!bclk) bad++;
            end
            if (ph == 0) begin
                if (!lrck) lr_low++;
                else begin ph = 1; lr_high = 1; end
            end else if (ph == 1) begin
                if (lrck) lr_high++;
                else ph = 2;
            end
            if (bclk) begin
                hr++; lrn = 0;
                if (hr > hi_run) hi_run = hr;
            end else begin
                lrn++; hr = 0;
                if (lrn > lo_run) lo_run = lrn;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_sequence(input int n, input string rate_req);
        int len, lo, hi, hr, lr, tk, bd;
        measure(len, lo, hi, hr, lr, tk, bd);
        check(len == n*2*HALF*CALW, "R6", "calibration length", len, n*2*HALF*CALW);
        check(lo == n*HALF, "R5", "left half length", lo, n*HALF);
        check(hi == n*HALF, "R5", "right half length", hi, n*HALF);
        check(hr == n-1, rate_req, "bclk high run", hr, n-1);
        check(lr == 1, rate_req, "bclk low run", lr, 1);
        check(tk == 2*HALF*CALW, "R4", "tick count", tk, 2*HALF*CALW);
        check(bd == 0, "R4", "ticks with bclk low", bd, 0);
    endtask

    task automatic test_reset_start();
        int len, lo, hi, hr, lr, tk, bd;
        rst = 1'b1; pdn = 1'b0; rate_sel = 1'b0;
        repeat (3) @(negedge clk);
        check({bclk, tick, lrck, cal} == 4'b0, "R1", "outputs in reset",
              int'({bclk, tick, lrck, cal}), 0);
        rst = 1'b0;
        measure(len, lo, hi, hr, lr, tk, bd);
        check(len == 2*2*HALF*CALW, "R9", "sequence after reset", len, 2*2*HALF*CALW);
    endtask

    task automatic test_power_down_hold();
        int busy = 0;
        pdn = 1'b1; rate_sel = 1'b1;
        @(negedge clk);
        repeat (20) begin
            @(negedge clk);
            if (bclk || tick || lrck || cal) busy++;
        end
        check(busy == 0, "R1", "cycles with activity in power-down", busy, 0);
    endtask

    task automatic test_release(input logic m, input string rate_req);
        pdn = 1'b1; rate_sel = m;
        repeat (3) @(negedge clk);
        pdn = 1'b0;
        check_sequence(m ? 3 : 2, rate_req);
    endtask

    task automatic test_after_done();
        int cal_hits = 0;
        int toggles = 0;
        logic prev = lrck;
        repeat (60) begin
            @(negedge clk);
            if (cal) cal_hits++;
            if (lrck != prev) toggles++;
            prev = lrck;
        end
        check(cal_hits == 0, "R7", "cal high after completion", cal_hits, 0);
        check(toggles >= 4, "R7", "lrck toggles after completion", toggles, 4);
    endtask

    task automatic test_abort();
        int len, lo, hi, hr, lr, tk, bd;
        pdn = 1'b1; rate_sel = 1'b0;
        repeat (3) @(negedge clk);
        pdn = 1'b0;
        repeat (30) @(negedge clk);
        check(cal == 1'b1, "R8", "cal mid sequence", int'(cal), 1);
        pdn = 1'b1;
        @(negedge clk);
        check(cal == 1'b0, "R8", "cal after abort", int'(cal), 0);
        check({bclk, lrck} == 2'b0, "R1", "clocks after abort", int'({bclk, lrck}), 0);
        repeat (2) @(negedge clk);
        pdn = 1'b0;
        measure(len, lo, hi, hr, lr, tk, bd);
        check(len == 2*2*HALF*CALW, "R8", "restarted length", len, 2*2*HALF*CALW);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset_start();
        test_power_down_hold();
        test_release(1'b1, "R3");
        test_after_done();
        test_release(1'b0, "R2");
        test_after_done();
        test_abort();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule